// File: doc/BRIEF.md
# Delayed power-good channel

This block is one channel of a supply supervisor in digital form. An external comparator reports, already synchronised to the block clock, whether the monitored rail sits above its threshold. The channel combines that flag with an active-high enable and a shared undervoltage-lockout flag into a single qualifying condition. Its power-good output rises only after the condition has held for a programmed number of clock cycles. It drops on the very next clock edge once the condition is lost.

A bypass select replaces the programmed count with a short fixed latency, set by a parameter. Several channels can be chained to sequence supplies, with the power-good bit of one channel driving the enable of the next. Analog comparison, hysteresis, threshold choice and output drive are handled elsewhere.

Top module: `pgood_delay_chan`

## Requirements
- R1: A synchronous active-high `rst` forces `pgood` low and clears the delay count, so after reset a full delay is needed before `pgood` rises.
- R2: With `en` sampled low at a clock edge, `pgood` is low after that edge, whatever `above_th` is.
- R3: With `above_th` sampled low at a clock edge, `pgood` is low after that edge, whatever `en` is.
- R4: With `uvlo` sampled high at a clock edge, `pgood` is low after that edge, whatever `en` and `above_th` are.
- R5: With `bypass` low and `dly_cnt` = N ≥ 1, `pgood` rises after the Nth consecutive edge at which the qualifying condition (`en` high, `above_th` high, `uvlo` low) is sampled true, and not before.
- R6: If the qualifying condition is lost before the delay expires, `pgood` stays low and the count starts again from zero when the condition returns.
- R7: A rising `en` while `above_th` is already high starts the delay in the same way as a rising `above_th`.
- R8: Once `pgood` is high, it stays high for as long as the condition holds, and later changes of `dly_cnt` or `bypass` do not affect it. The timer is cleared at the rise.
- R9: With `bypass` high, `pgood` rises after RISE_LAT consecutive qualified edges (default 4), whatever `dly_cnt` holds. This is longer than the one-edge fall.
- R10: A `dly_cnt` of 0 with `bypass` low behaves as a delay of one qualified edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| above_th | input | 1 | Comparator flag: monitored rail above threshold |
| en | input | 1 | Active-high channel enable |
| uvlo | input | 1 | Undervoltage lockout, forces output low |
| bypass | input | 1 | Selects the fixed short rising latency instead of `dly_cnt` |
| dly_cnt | input | CW | Rising delay in qualified clock cycles |
| pgood | output | 1 | Power-good output |

## Verification
Directed sequences separate the main cases:
- An unbroken qualified run shows the exact rise edge for a programmed delay.
- A run broken one cycle short of expiry shows that the count restarts rather than resumes.
- An enable rising over an already-high comparator flag shows that the enable alone can start the count.
- Drops of each input from the high state show the one-edge fall and which input caused it.
- Bypass with a large programmed count, and a zero count, separate the two sources of the rising limit.

Random stretches mix short glitches on every input with changes of mode and count, and are checked against a cycle model.

// File: rtl/pgood_delay_chan.sv
module pgood_delay_chan #(
  parameter int unsigned CW       = 16,
  parameter int unsigned RISE_LAT = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          above_th,
  input  logic          en,
  input  logic          uvlo,
  input  logic          bypass,
  input  logic [CW-1:0] dly_cnt,
  output logic          pgood
);

  localparam logic [CW-1:0] BYP_LIM = CW'(RISE_LAT);

  logic [CW-1:0] cnt;
  logic [CW-1:0] limit;
  logic [CW:0]   nxt;
  logic          qual;
  logic          hit;

  assign qual  = en & above_th & ~uvlo;
  assign limit = bypass ? BYP_LIM : ((dly_cnt == '0) ? CW'(1) : dly_cnt);
  assign nxt   = {1'b0, cnt} + 1'b1;
  assign hit   = nxt >= {1'b0, limit};

  always_ff @(posedge clk) begin
    if (rst || !qual) begin
      pgood <= 1'b0;
      cnt   <= '0;
    end else if (pgood) begin
      cnt   <= '0;
    end else if (hit) begin
      pgood <= 1'b1;
      cnt   <= '0;
    end else begin
      cnt   <= nxt[CW-1:0];
    end
  end

  p_en_low_r2: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !pgood);

  p_below_r3: assert property (@(posedge clk) disable iff (rst)
    !$past(above_th) |-> !pgood);

  p_lockout_r4: assert property (@(posedge clk) disable iff (rst)
    $past(uvlo) |-> !pgood);

  p_rise_qualified_r5: assert property (@(posedge clk) disable iff (rst)
    $rose(pgood) |-> ($past(en) && $past(above_th) && !$past(uvlo) && !$past(rst)));

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (pgood && en && above_th && !uvlo) |=> pgood);

  p_timer_clear_r8: assert property (@(posedge clk) disable iff (rst)
    pgood |-> (cnt == '0));

endmodule

// File: tb/test_pgood_delay_chan.sv
module test_pgood_delay_chan;
  localparam int unsigned CW = 16;
  localparam int unsigned RL = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic above_th = 1'b0, en = 1'b0, uvlo = 1'b0, bypass = 1'b0;
  logic [CW-1:0] dly_cnt = '0;
  logic pgood;

  int checks = 0;
  int errors = 0;
  logic m_pg = 1'b0;
  int   m_run = 0;

  always #10 clk = ~clk;

  pgood_delay_chan #(.CW(CW), .RISE_LAT(RL)) i_pgood_delay_chan (
    .clk(clk), .rst(rst), .above_th(above_th), .en(en), .uvlo(uvlo),
    .bypass(bypass), .dly_cnt(dly_cnt), .pgood(pgood));

  function automatic int lim_of(input logic b, input logic [CW-1:0] d);
    if (b) return RL;
    return (d == 0) ? 1 : int'(d);
  endfunction

  function automatic logic qual_of(input logic e, input logic a, input logic u);
    return e & a & ~u;
  endfunction

  task automatic cyc(input logic e, input logic a, input logic u, input logic b,
                     input logic [CW-1:0] d, input string tag);
    en = e; above_th = a; uvlo = u; bypass = b; dly_cnt = d;
    @(posedge clk);
    if (rst || !qual_of(e, a, u)) begin
      m_pg = 1'b0; m_run = 0;
    end else if (!m_pg) begin
      if (m_run + 1 >= lim_of(b, d)) begin m_pg = 1'b1; m_run = 0; end
      else m_run = m_run + 1;
    end
    @(negedge clk);
    checks++;
    if (pgood !== m_pg) begin
      errors++;
      $display("FAIL %s: pgood actual=%b expected=%b at %0t", tag, pgood, m_pg, $time);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run actual=hung expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    @(negedge clk);
    // R1: reset state with a qualifying input present
    rst = 1'b1;
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 5, "R1");
    rst = 1'b0;
    // R5: unbroken run, delay 5
    for (int i = 0; i < 7; i++) cyc(1, 1, 0, 0, 5, "R5");
    // R8: hold while qualified, delay and mode changed
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, i[0], CW'(i * 9), "R8");
    // R3: drop of comparator flag
    cyc(1, 0, 0, 0, 5, "R3");
    // R6: break one short of expiry, then restart
    for (int i = 0; i < 4; i++) cyc(1, 1, 0, 0, 5, "R6");
    cyc(1, 0, 0, 0, 5, "R6");
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 0, 5, "R6");
    // R2: enable drop from high
    cyc(0, 1, 0, 0, 5, "R2");
    // R7: enable rising over high flag
    for (int i = 0; i < 3; i++) cyc(0, 1, 0, 0, 3, "R7");
    for (int i = 0; i < 5; i++) cyc(1, 1, 0, 0, 3, "R7");
    // R4: lockout from high
    cyc(1, 1, 1, 0, 3, "R4");
    cyc(1, 1, 1, 0, 3, "R4");
    // R9: bypass ignores a large count
    for (int i = 0; i < 6; i++) cyc(1, 1, 0, 1, 1000, "R9");
    cyc(1, 0, 0, 1, 1000, "R9");
    // R10: zero count means one edge
    cyc(1, 1, 0, 0, 0, "R10");
    cyc(1, 1, 0, 0, 0, "R10");
    // R1: reset mid-count restarts the delay
    cyc(0, 1, 0, 0, 6, "R1");
    for (int i = 0; i < 3; i++) cyc(1, 1, 0, 0, 6, "R1");
    rst = 1'b1; cyc(1, 1, 0, 0, 6, "R1"); rst = 1'b0;
    for (int i = 0; i < 7; i++) cyc(1, 1, 0, 0, 6, "R1");
    // random phase
    void'($urandom(32'h5eed_0042));
    for (int i = 0; i < 3000; i++) begin
      cyc(($urandom % 8) != 0, ($urandom % 8) != 0, ($urandom % 32) == 0,
          ($urandom % 4) == 0, CW'($urandom % 8), "R5");
    end
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule